// File: doc/BRIEF.md
# Clock Stop Throttle Duty Generator

This block slows a processor by pulsing an active-low clock-stop request inside a repeating window of 1024 clock cycles. Each window opens with the request held low for a number of cycles picked by a 3-bit duty code. For the rest of the window the request is high. Larger codes give shorter low phases, so the processor keeps more of its performance.

Two sources can start throttling. The first is software, through an enable bit and a duty field. The second is a thermal override input, which has no enable and uses its own duty field. That thermal field can be written once after each bus reset. A power-state input limits all throttling to the fully running state. A status output reports whether throttling is in progress.

Duty codes are sampled only when a window starts. A window therefore always completes with the width it began with.

Top module: `stopclk_throttle`

## Requirements
- R1: While `rst_n` is low, `stop_n` is 1 and `throttling` is 0. Reset also does three more things: both duty fields become 000, the software enable clears, and the thermal field unlocks so that it accepts one write again.
- R2: While throttling runs, the pattern repeats every 1024 cycles. Each window starts with `stop_n` low, and the low phase comes first. Its length in cycles depends on the duty code: 001 gives 896, 010 gives 768, 011 gives 640, 100 gives 512, 101 gives 384, 110 gives 256 and 111 gives 128.
- R3: Duty code 000 behaves as 50%, a low phase of 512 cycles.
- R4: A pulse on `wr_sw` loads the enable from `wr_sw_en` and the software duty from `wr_sw_duty`. When the enable is set and `pwr_state` is 00, throttling runs with the software duty. It begins one cycle after the register takes the write.
- R5: When `therm_ovr` is high and `pwr_state` is 00, throttling runs with the thermal duty field, whatever the software enable. Throttling begins on the first clock edge that sees the input high.
- R6: The first `wr_therm` pulse after reset loads `wr_therm_duty` into the thermal field. Every later pulse leaves the field unchanged until `rst_n` is asserted again.
- R7: When `pwr_state` is anything other than 00, no throttling occurs: `stop_n` stays 1 and `throttling` is 0. This covers 10, the low-power halt state.
- R8: `throttling` is 1 throughout every window while throttling runs, during both the low and the high phase. It is 0 otherwise.
- R9: When `therm_ovr` is high and software throttling is also enabled, the thermal duty field sets the low phase.
- R10: A change of duty code, or of the source that selects it, takes effect at the next window boundary. If a write lands on the clock edge that ends a window, the new value takes effect one window later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low |
| wr_sw | input | 1 | Write strobe for the software enable and duty |
| wr_sw_en | input | 1 | Software throttling enable value to write |
| wr_sw_duty | input | 3 | Software duty code to write |
| wr_therm | input | 1 | Write strobe for the thermal duty field |
| wr_therm_duty | input | 3 | Thermal duty code to write |
| therm_ovr | input | 1 | Thermal override condition, active high |
| pwr_state | input | 2 | Processor power state, 00 = fully running, 10 = halt |
| stop_n | output | 1 | Clock-stop request, active low |
| throttling | output | 1 | Status: 1 while throttling is in progress |

## Verification
Two functions can act on the same clock edge: a register write, and the reload of the duty code at the end of a window. The bench provokes this by timing a software duty write to land exactly on the closing edge of the first window. It then checks that the second window still has the old width and the third has the new one. It also raises the thermal override partway through a low phase while software throttling is running. In that case the current pulse must finish at the software width, and the next window must switch to the thermal width.

// File: rtl/sct_pkg.sv
package sct_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'b00,
      PS_C1   = 2'b01,
      PS_HALT = 2'b10,
      PS_C3   = 2'b11
   } pstate_e;

   // Low-phase length for a duty code in a window of 2**pw cycles.
   // Code 0 maps to half the window; otherwise (2**cw - code) steps.
   function automatic int unsigned stop_len(int unsigned code,
                                            int unsigned pw,
                                            int unsigned cw);
      if (code == 0) return 32'd1 << (pw - 1);
      return ((32'd1 << cw) - code) << (pw - cw);
   endfunction

endpackage

// File: rtl/sct_regs.sv
module sct_regs #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sw,
   input  logic              wr_sw_en,
   input  logic [CODE_W-1:0] wr_sw_duty,
   input  logic              wr_therm,
   input  logic [CODE_W-1:0] wr_therm_duty,
   output logic              sw_en,
   output logic [CODE_W-1:0] sw_duty,
   output logic [CODE_W-1:0] therm_duty,
   output logic              therm_lock
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_en   <= 1'b0;
         sw_duty <= '0;
      end else if (wr_sw) begin
         sw_en   <= wr_sw_en;
         sw_duty <= wr_sw_duty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm_duty <= '0;
         therm_lock <= 1'b0;
      end else if (wr_therm && !therm_lock) begin
         therm_duty <= wr_therm_duty;
         therm_lock <= 1'b1;
      end
   end

   // Once locked, a thermal write must not move the field.
   assert_therm_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_lock && wr_therm) |=> $stable(therm_duty));

endmodule

// File: rtl/sct_period.sv
module sct_period
   import sct_pkg::*;
#(
   parameter int PERIOD_W = 10,
   parameter int CODE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [CODE_W-1:0] code,
   output logic              stop_n,
   output logic              running
);

   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] len;
   logic [PERIOD_W-1:0] next_len;
   logic                at_end;

   assign next_len = PERIOD_W'(stop_len(32'(code), PERIOD_W, CODE_W));
   assign at_end   = &cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
         len     <= '0;
      end else if (!active) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!running || at_end) begin
         running <= 1'b1;
         cnt     <= '0;
         len     <= next_len;
      end else begin
         cnt     <= cnt + PERIOD_W'(1);
      end
   end

   assign stop_n = !(running && (cnt < len));

   // The pulse width is frozen inside a window.
   assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && cnt != '0) |-> $stable(len));

   // The window opens with the low phase.
   assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> !stop_n);

endmodule

// File: rtl/stopclk_throttle.sv
module stopclk_throttle
   import sct_pkg::*;
#(
   parameter int PERIOD_W = 10,
   parameter int CODE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sw,
   input  logic              wr_sw_en,
   input  logic [CODE_W-1:0] wr_sw_duty,
   input  logic              wr_therm,
   input  logic [CODE_W-1:0] wr_therm_duty,
   input  logic              therm_ovr,
   input  logic [1:0]        pwr_state,
   output logic              stop_n,
   output logic              throttling
);

   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
      if (PERIOD_W <= CODE_W) begin : g_bad_period
         $error("PERIOD_W must exceed CODE_W");
      end
   endgenerate

   logic              sw_en;
   logic [CODE_W-1:0] sw_duty;
   logic [CODE_W-1:0] therm_duty;
   logic              therm_lock;
   logic              in_run;
   logic              active;
   logic [CODE_W-1:0] sel_code;

   sct_regs #(.CODE_W(CODE_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_sw         (wr_sw),
      .wr_sw_en      (wr_sw_en),
      .wr_sw_duty    (wr_sw_duty),
      .wr_therm      (wr_therm),
      .wr_therm_duty (wr_therm_duty),
      .sw_en         (sw_en),
      .sw_duty       (sw_duty),
      .therm_duty    (therm_duty),
      .therm_lock    (therm_lock)
   );

   assign in_run   = (pwr_state == PS_RUN);
   assign active   = in_run && (therm_ovr || sw_en);
   assign sel_code = therm_ovr ? therm_duty : sw_duty;

   sct_period #(.PERIOD_W(PERIOD_W), .CODE_W(CODE_W)) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .code    (sel_code),
      .stop_n  (stop_n),
      .running (throttling)
   );

   // Outside the running state throttling stops on the next edge.
   assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 2'b00) |=> !throttling);

   // A stop request is only issued while throttling is reported.
   assert_status_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> throttling);

endmodule

// File: tb/test_stopclk_throttle.sv
module test_stopclk_throttle;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_sw = 1'b0;
   logic       wr_sw_en = 1'b0;
   logic [2:0] wr_sw_duty = 3'd0;
   logic       wr_therm = 1'b0;
   logic [2:0] wr_therm_duty = 3'd0;
   logic       therm_ovr = 1'b0;
   logic [1:0] pwr_state = 2'b00;
   logic       stop_n;
   logic       throttling;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int    exp_q[$];
   string req_q[$];
   int    run_len = 0;

   always #2 clk = ~clk;

   stopclk_throttle i_stopclk_throttle (
      .clk(clk), .rst_n(rst_n), .wr_sw(wr_sw), .wr_sw_en(wr_sw_en),
      .wr_sw_duty(wr_sw_duty), .wr_therm(wr_therm), .wr_therm_duty(wr_therm_duty),
      .therm_ovr(therm_ovr), .pwr_state(pwr_state),
      .stop_n(stop_n), .throttling(throttling)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input int len, input int k, input string req);
      for (int i = 0; i < k; i++) begin
         exp_q.push_back(len);
         req_q.push_back(req);
      end
   endtask

   task automatic sw_write(input bit en, input logic [2:0] duty);
      wr_sw = 1'b1; wr_sw_en = en; wr_sw_duty = duty;
      @(negedge clk);
      wr_sw = 1'b0;
   endtask

   task automatic therm_write(input logic [2:0] duty);
      wr_therm = 1'b1; wr_therm_duty = duty;
      @(negedge clk);
      wr_therm = 1'b0;
   endtask

   // Monitor: measures each low pulse and compares it with the queue.
   always @(negedge clk) begin
      if (!rst_n) begin
         run_len = 0;
      end else if (!stop_n) begin
         run_len++;
      end else if (run_len > 0) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected pulse", run_len, 0);
         end else begin
            int    e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(run_len == e, r, run_len, e);
         end
         run_len = 0;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cycles(3);
      check(stop_n == 1'b1, "R1 stop_n in reset", stop_n, 1);
      check(throttling == 1'b0, "R1 status in reset", throttling, 0);
      rst_n = 1'b1;
      cycles(3);

      // R3: software code 000 gives 512, two windows
      push(512, 2, "R3 code000 software");
      sw_write(1'b1, 3'd0);
      cycles(2047);
      sw_write(1'b0, 3'd0);
      cycles(4);

      // R2/R4/R8: sweep codes 1..7, one window each
      for (int c = 1; c < 8; c++) begin
         push((8 - c) * 128, 1, "R2 duty sweep");
         sw_write(1'b1, 3'(c));
         cycles(950);
         check(throttling == 1'b1, "R8 status in high phase", throttling, 1);
         check(stop_n == 1'b1, "R4 high phase", stop_n, 1);
         cycles(73);
         sw_write(1'b0, 3'd0);
         cycles(4);
         check(throttling == 1'b0, "R8 status idle", throttling, 0);
      end

      // R5/R6: thermal field locked to 111 by the first write
      therm_write(3'd7);
      therm_write(3'd1);
      cycles(2);
      push(128, 1, "R6 write-once thermal");
      therm_ovr = 1'b1;
      cycles(1024);
      therm_ovr = 1'b0;
      cycles(4);

      // R9/R10: override raised mid-pulse while software runs 010
      push(768, 1, "R10 first window keeps software width");
      push(128, 1, "R9 thermal priority");
      sw_write(1'b1, 3'd2);
      cycles(499);
      therm_ovr = 1'b1;
      cycles(1548);
      therm_ovr = 1'b0;
      sw_write(1'b0, 3'd0);
      cycles(4);

      // R10: write landing on the window-closing edge
      push(512, 2, "R10 boundary write deferred");
      push(256, 1, "R10 new width applied");
      sw_write(1'b1, 3'd4);
      cycles(1024);
      sw_write(1'b1, 3'd6);
      cycles(2046);
      sw_write(1'b0, 3'd0);
      cycles(4);

      // R7: halt state blocks both sources
      begin
         int lows;
         int busy;
         lows = 0;
         busy = 0;
         pwr_state = 2'b10;
         sw_write(1'b1, 3'd1);
         therm_ovr = 1'b1;
         for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (!stop_n) lows++;
            if (throttling) busy++;
         end
         check(lows == 0, "R7 no stop pulses in halt", lows, 0);
         check(busy == 0, "R7 no status in halt", busy, 0);
         therm_ovr = 1'b0;
         sw_write(1'b0, 3'd0);
         pwr_state = 2'b00;
         cycles(4);
      end

      // R1: reset clears the thermal field and its lock
      rst_n = 1'b0;
      cycles(2);
      check(stop_n == 1'b1, "R1 stop_n after reset", stop_n, 1);
      rst_n = 1'b1;
      cycles(2);
      push(512, 1, "R1 thermal field cleared to 000");
      therm_ovr = 1'b1;
      cycles(1024);
      therm_ovr = 1'b0;
      cycles(4);
      therm_write(3'd6);
      cycles(2);
      push(256, 1, "R1 lock released by reset");
      therm_ovr = 1'b1;
      cycles(1024);
      therm_ovr = 1'b0;
      cycles(8);

      check(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule